// File: doc/BRIEF.md
# Edge-Timed Phase-Frequency Detector with Lock Window

This block compares two divided edge trains: a reference train and a train taken from the oscillator under control. Both arrive as level signals already synchronous to a fast sampling clock, and the block acts on their rising edges. It produces a coarse correction made of an up pulse, a down pulse and an output enable that models a three-state driver. It also produces an active-low lock indicator.

Between the two edges of a pair, the block counts sampling-clock cycles. When that count falls inside a window supplied on an input port, the coarse driver is released to high impedance and lock is flagged. Outside the window the coarse driver stays enabled, which keeps channel changes fast. A larger loop would use the up and down pulses to steer a charge pump. It would read the lock indicator as an open-drain flag, where 0 means pulling low and 1 means released.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with no edge yet seen, `pd_up_o` and `pd_dn_o` are 0 and `pd_oe_o` and `lock_n_o` are 1.
- R2: A rising edge of `fv_i` that arrives d cycles before the rising edge of `fr_i` raises `pd_up_o` in the cycle after the `fv_i` edge is sampled. `pd_up_o` then stays high for exactly d cycles while `pd_dn_o` stays 0.
- R3: A rising edge of `fr_i` that arrives d cycles before the rising edge of `fv_i` raises `pd_dn_o` in the same way, for exactly d cycles, while `pd_up_o` stays 0.
- R4: Rising edges of both inputs sampled in the same cycle complete a pair with error 0 and raise no pulse. `pd_up_o` and `pd_dn_o` are never high together.
- R5: Each completed pair is judged once. In the cycle after completion, lock is asserted (`lock_n_o`=0) if its error d is at most `win_i` and deasserted if it is larger. The boundary d = `win_i` locks.
- R6: `pd_oe_o` is 0 exactly while lock is asserted and 1 otherwise, so the coarse output is high impedance only when locked.
- R7: While a pair is still open, lock drops in the cycle after its running count exceeds `win_i`, without waiting for the second edge.
- R8: The error count saturates at 2^CNT_W-1 and never wraps. With `win_i` below that value, an error of 2^CNT_W+2 cycles never locks.
- R9: With `win_i` = 0, only coincident edges lock, and an error of one cycle unlocks.
- R10: A second rising edge on the same input while its pulse is already high is absorbed. The pulse continues until the other input's edge arrives, so a frequency mismatch yields pulses of one sign only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_i | input | 1 | Divided reference train |
| fv_i | input | 1 | Divided oscillator train |
| win_i | input | CNT_W | Lock window in sampling-clock cycles |
| pd_up_o | output | 1 | Up pulse (oscillator side early or fast) |
| pd_dn_o | output | 1 | Down pulse (reference side early) |
| pd_oe_o | output | 1 | Coarse driver enable; 0 models high impedance |
| lock_n_o | output | 1 | Lock flag, 0 = locked, 1 = released |

## Verification
The bench builds the block with CNT_W = 6, so the error counter tops out at 63 cycles. At that width, input periods of about 200 cycles can push a phase offset of 66 cycles past saturation. A counter that wraps would fold that offset back to 2, inside a window of 5, and so be exposed. Windows from 0 to 9 with periods of 8 to 40 cycles place the boundary d = `win_i`, the zero window, and early unlock during an open pair all within a few hundred cycles of each segment.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_state_t;

  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_VCO = 1;
  localparam int unsigned N_CH   = 2;
endpackage

// File: rtl/pfd_edge_rise.sv
module pfd_edge_rise (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_ref_i,
  input  logic             rise_vco_i,
  output pfd_state_t       st_o,
  output logic             pending_o,
  output logic             done_o,
  output logic [CNT_W-1:0] err_o
);
  localparam logic [CNT_W-1:0] ERR_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  pfd_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             up_set, dn_set, done;
  logic [CNT_W-1:0] run;

  // A first edge sets its side; the opposite edge closes the pair.
  assign up_set = st_q.up | rise_vco_i;
  assign dn_set = st_q.dn | rise_ref_i;
  assign done   = up_set & dn_set;

  assign pending_o = st_q.up | st_q.dn;
  assign run       = (cnt_q == ERR_MAX) ? ERR_MAX : cnt_q + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q.up <= up_set & ~done;
      st_q.dn <= dn_set & ~done;
      if (done || !pending_o) cnt_q <= '0;
      else                    cnt_q <= run;
    end
  end

  assign st_o   = st_q;
  assign done_o = done;
  assign err_o  = pending_o ? run : '0;
endmodule

// File: rtl/pfd_lock_eval.sv
module pfd_lock_eval #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic             pending_i,
  input  logic [CNT_W-1:0] err_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             lock_o
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (done_i) begin
      lock_q <= (err_i <= win_i);
    end else if (pending_i && (err_i > win_i)) begin
      lock_q <= 1'b0;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fr_i,
  input  logic             fv_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             pd_up_o,
  output logic             pd_dn_o,
  output logic             pd_oe_o,
  output logic             lock_n_o
);
  logic [N_CH-1:0]  sig_in;
  logic [N_CH-1:0]  rise;
  pfd_state_t       st;
  logic             pending, done, lock;
  logic [CNT_W-1:0] err;

  assign sig_in[CH_REF] = fr_i;
  assign sig_in[CH_VCO] = fv_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_edge
    pfd_edge_rise u_edge (
      .clk    (clk),
      .rst    (rst),
      .sig_i  (sig_in[g]),
      .rise_o (rise[g])
    );
  end

  pfd_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .rise_ref_i (rise[CH_REF]),
    .rise_vco_i (rise[CH_VCO]),
    .st_o       (st),
    .pending_o  (pending),
    .done_o     (done),
    .err_o      (err)
  );

  pfd_lock_eval #(.CNT_W(CNT_W)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .done_i    (done),
    .pending_i (pending),
    .err_i     (err),
    .win_i     (win_i),
    .lock_o    (lock)
  );

  assign pd_up_o  = st.up;
  assign pd_dn_o  = st.dn;
  assign pd_oe_o  = ~lock;
  assign lock_n_o = ~lock;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             fr_i,
  input logic             fv_i,
  input logic [CNT_W-1:0] win_i,
  input logic             pd_up_o,
  input logic             pd_dn_o,
  input logic             lock_n_o
);
  localparam logic [CNT_W:0] RUN_MAX = '1;
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                        run_q <= '0;
    else if (!(pd_up_o || pd_dn_o)) run_q <= '0;
    else if (run_q != RUN_MAX)      run_q <= run_q + 1'b1;
  end

  // R1
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!pd_up_o && !pd_dn_o && lock_n_o));

  // R2
  p_up_src_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_up_o) |-> ($past(fv_i) && !$past(fv_i, 2)));

  // R3
  p_dn_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_dn_o) |-> ($past(fr_i) && !$past(fr_i, 2)));

  // R4
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(pd_up_o && pd_dn_o));

  // R7
  p_pulse_bound_r7: assert property (@(posedge clk) disable iff (rst)
    ((pd_up_o || pd_dn_o) && !lock_n_o) |-> ({1'b0, win_i} >= run_q));

  // R7
  p_drop_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_n_o) |-> $past(pd_up_o || pd_dn_o));
endmodule

bind pfd_lock_top pfd_lock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fr_i     (fr_i),
  .fv_i     (fv_i),
  .win_i    (win_i),
  .pd_up_o  (pd_up_o),
  .pd_dn_o  (pd_dn_o),
  .lock_n_o (lock_n_o)
);

// File: tb/test_pfd_lock_top.sv
module test_pfd_lock_top;
  localparam int unsigned CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fr  = 1'b0;
  logic             fv  = 1'b0;
  logic [CNT_W-1:0] win = '0;
  logic             up, dn, oe, lk_n;

  int n_chk = 0;
  int n_err = 0;
  int t     = 0;
  int cyc   = 0;
  bit done_run = 1'b0;

  // reference model state
  bit m_up, m_dn, m_lock, m_frp, m_fvp;
  int m_age;

  pfd_lock_top #(.CNT_W(CNT_W)) i_pfd_lock_top (
    .clk(clk), .rst(rst), .fr_i(fr), .fv_i(fv), .win_i(win),
    .pd_up_o(up), .pd_dn_o(dn), .pd_oe_o(oe), .lock_n_o(lk_n)
  );

  always #10 clk = ~clk;

  // Model written from the requirements: the pair error is the number of
  // cycles between the two rising edges; unbounded integers, no saturation.
  always @(posedge clk) begin
    bit rr, rv, a_up, a_dn;
    int d;
    if (rst) begin
      m_up <= 0; m_dn <= 0; m_lock <= 0; m_age <= 0; m_frp <= 0; m_fvp <= 0;
    end else begin
      rr = fr && !m_frp;
      rv = fv && !m_fvp;
      m_frp <= fr;
      m_fvp <= fv;
      a_up = m_up || rv;
      a_dn = m_dn || rr;
      if (a_up && a_dn) begin
        d = (m_up || m_dn) ? m_age + 1 : 0;
        m_lock <= (d <= int'(win));
        m_up <= 0; m_dn <= 0; m_age <= 0;
      end else begin
        m_up <= a_up;
        m_dn <= a_dn;
        if (m_up || m_dn) begin
          m_age <= m_age + 1;
          if (m_age + 1 > int'(win)) m_lock <= 0;
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b at t=%0d", tag, what, act, exp, t);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "pd_up_o", up, m_up);
    check(tag, "pd_dn_o", dn, m_dn);
    check(tag, "lock_n_o", lk_n, !m_lock);
    check(tag, "pd_oe_o", oe, !m_lock);
  endtask

  task automatic do_reset(input int w);
    @(negedge clk);
    rst = 1'b1; fr = 1'b0; fv = 1'b0; win = CNT_W'(w);
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", "pd_up_o", up, 1'b0);
    check("R1", "pd_dn_o", dn, 1'b0);
    check("R1", "pd_oe_o", oe, 1'b1);
    check("R1", "lock_n_o", lk_n, 1'b1);
    rst = 1'b0;
    t = 0;
    @(negedge clk);
    check("R1", "lock_n_o", lk_n, 1'b1);
    check("R1", "pd_up_o", up, 1'b0);
  endtask

  task automatic run(input string tag, input int pr, input int pv, input int off, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all(tag);
      fr = (t % pr) < (pr / 2);
      fv = ((t + off) % pv) < (pv / 2);
      t++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_run) begin
      done_run = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(5);
    run("R4", 20, 20, 0, 200);    // coincident edges, no pulse, lock
    run("R2", 20, 20, 3, 200);    // fv leads by 3, up pulses, locked
    do_reset(5);
    run("R3", 20, 20, 17, 200);   // fr leads by 3, down pulses
    run("R5", 30, 30, 5, 200);    // d == win locks
    run("R5", 30, 30, 6, 200);    // d == win+1 unlocks
    do_reset(5);
    run("R7", 40, 40, 2, 200);    // lock first
    run("R7", 40, 40, 20, 200);   // open pair overruns window
    do_reset(5);
    run("R8", 200, 200, 66, 1000); // 66 = 2^6+2, would wrap to 2
    do_reset(0);
    run("R9", 16, 16, 0, 100);
    run("R9", 16, 16, 1, 100);
    do_reset(4);
    run("R10", 20, 23, 0, 600);   // fr faster: only down pulses
    run("R10", 23, 20, 0, 600);   // fv faster: only up pulses
    for (int k = 0; k < 20; k++) begin
      int w, pr, pv, off;
      w  = int'($urandom % 10);
      pr = 8 + int'($urandom % 30);
      pv = pr;
      if ($urandom % 3 != 0) pv = pr + int'($urandom % 5) - 2;
      off = int'($urandom % pv);
      do_reset(w);
      run("R6", pr, pv, off, 300);
    end
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule